// File: doc/BRIEF.md
# Vectored Multi-Source Interrupt Controller

This block gathers a parameterised number of peripheral interrupt lines into a single request toward a soft processor. Each input is fixed at build time as level-sensitive (active high or active low) or edge-sensitive (rising or falling). Every input passes through a two-flop synchroniser before it is examined. A detected event sets a bit in a status register. Software masks the status with an enable register, acknowledges bits by writing ones, and reads a vector register that names the highest-priority pending source. Input 0 has the highest priority.

A two-bit mode register gates the output. Bit 0 lets the request reach the processor. Bit 1 lets the hardware inputs record events. While bit 1 is clear, software may set status bits directly so that interrupts can be produced for test. When the `FAST` parameter is set, the controller registers the request together with a handler address taken from a writable per-source table. It holds both until the processor signals handler entry on a two-bit acknowledge input. It then clears the serviced source by itself: an edge source is cleared on entry and a level source on return.

Top module: `irq_concentrator`

## Requirements
- R1: The register words are: 0 status, 1 pending (read-only), 2 enable, 3 acknowledge (write-only, reads 0), 4 vector (read-only), 5 mode, and 16+i handler address of source i (reads 0 when `FAST` is 0). Any other word reads 0. After reset, every register reads 0 except the vector, and `irq_o` and `irq_addr_o` are 0.
- R2: A level input is active when it equals its polarity bit in `ACT_HIGH`. It sets its status bit on the third rising clock edge after it becomes active, and it sets the bit again on every edge while it stays active, even straight after an acknowledge.
- R3: An edge input sets its status bit on one transition: 0 to 1 when its `ACT_HIGH` bit is 1, and 1 to 0 otherwise. The bit stays set after the input returns, until it is acknowledged.
- R4: Mode bit 1 (hardware enable) gates hardware events into status. While mode bit 1 is 0, a write to word 0 ORs the write data into status. While mode bit 1 is 1, writes to word 0 are ignored.
- R5: The request output requires mode bit 0. With `FAST`=0, `irq_o` equals mode bit 0 AND any pending bit. With `FAST`=1, a request is raised only from an idle cycle in which mode bit 0 is 1 and some bit is pending.
- R6: Writing to word 3 clears every status bit whose data bit is 1 and leaves the other bits unchanged.
- R7: Pending equals status AND enable. The vector holds the lowest pending index, or all ones when nothing is pending.
- R8: With `FAST`=1, `irq_o` rises one edge after the idle decision. `irq_addr_o` then carries the table entry of the lowest pending index. Both stay unchanged until `cpu_ack` reads 01.
- R9: With `FAST`=1, `cpu_ack`=01 while the request is raised drops `irq_o` and clears the source if it is edge-sensitive. After that, `cpu_ack`=10 returns the controller to idle and clears the source if it is level-sensitive. Any other code, or a code outside its state, has no effect.
- R10: When several sources are pending at once, they are presented one at a time in index order. A lower-priority source is presented only after the higher one has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Peripheral interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data for `bus_addr` (combinational) |
| cpu_ack | input | 2 | Processor acknowledge code (01 on entry, 10 on return) |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_addr_o | output | DW | Handler address of the presented source (fast mode) |

## Verification
The bound checker watches the processor-facing handshake on every cycle. In fast mode, the request and its address must hold until the entry code arrives, and the request must drop on that code. In either mode, a request must never appear without output enable. The sensitivity decoding, the latency through the synchroniser and the re-assertion of level sources can only be shown by the bench's scenarios. The same is true of the gating of software and hardware status writes, the priority order of back-to-back sources, and the split between clearing edge sources on entry and level sources on return. The bench's cycle model covers both a fast and a plain instance driven with the same stimulus.

// File: rtl/irq_concentrator.sv
module irq_concentrator #(
  parameter int N_SRC = 4,
  parameter int DW = 32,
  parameter int AW = 5,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '1,
  parameter logic [N_SRC-1:0] ACT_HIGH = '1,
  parameter bit FAST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [1:0]       cpu_ack,
  output logic             irq_o,
  output logic [DW-1:0]    irq_addr_o
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_PEND = AW'(1);
  localparam logic [AW-1:0] A_EN   = AW'(2);
  localparam logic [AW-1:0] A_ACK  = AW'(3);
  localparam logic [AW-1:0] A_VEC  = AW'(4);
  localparam logic [AW-1:0] A_MODE = AW'(5);
  localparam logic [AW-1:0] TBL_BASE = AW'(2 ** (AW - 1));

  logic [N_SRC-1:0] s1, s2, s3, act, stat, en, pend, hw_set, sw_set, sw_clr, fclr;
  logic [1:0] mer;
  logic [IW-1:0] top;
  logic found;
  logic [AW-1:0] tbl_off;
  logic in_tbl;
  logic [DW-1:0] tbl_rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= ~ACT_HIGH;
      s2 <= ~ACT_HIGH;
      s3 <= ~ACT_HIGH;
    end else begin
      s1 <= src_i;
      s2 <= s1;
      s3 <= s2;
    end

  for (genvar i = 0; i < N_SRC; i++) begin : g_sense
    if (LEVEL_MASK[i]) begin : g_lvl
      assign act[i] = (s2[i] == ACT_HIGH[i]);
    end else if (ACT_HIGH[i]) begin : g_rise
      assign act[i] = s2[i] & ~s3[i];
    end else begin : g_fall
      assign act[i] = ~s2[i] & s3[i];
    end
  end

  assign pend   = stat & en;
  assign hw_set = mer[1] ? act : '0;
  assign sw_set = (bus_wr && bus_addr == A_STAT && !mer[1]) ? bus_wdata[N_SRC-1:0] : '0;
  assign sw_clr = (bus_wr && bus_addr == A_ACK) ? bus_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
      mer  <= '0;
    end else begin
      stat <= (stat & ~sw_clr & ~fclr) | hw_set | sw_set;
      if (bus_wr && bus_addr == A_EN) en <= bus_wdata[N_SRC-1:0];
      if (bus_wr && bus_addr == A_MODE) mer <= bus_wdata[1:0];
    end

  always_comb begin
    top = '0;
    found = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) begin
        top = i[IW-1:0];
        found = 1'b1;
      end
  end

  assign tbl_off = bus_addr - TBL_BASE;
  assign in_tbl  = bus_addr[AW-1] && (tbl_off < AW'(N_SRC));

  if (FAST) begin : g_fast
    typedef enum logic [1:0] {F_IDLE, F_WAIT, F_SVC} fstate_t;
    fstate_t st;
    logic [IW-1:0] cur;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] tbl [N_SRC];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st <= F_IDLE;
        cur <= '0;
        addr_q <= '0;
        for (int i = 0; i < N_SRC; i++) tbl[i] <= '0;
      end else begin
        if (bus_wr && in_tbl) tbl[tbl_off[IW-1:0]] <= bus_wdata;
        case (st)
          F_IDLE: if (mer[0] && found) begin
            st <= F_WAIT;
            cur <= top;
            addr_q <= tbl[top];
          end
          F_WAIT: if (cpu_ack == 2'b01) st <= F_SVC;
          F_SVC:  if (cpu_ack == 2'b10) st <= F_IDLE;
          default: st <= F_IDLE;
        endcase
      end

    always_comb begin
      fclr = '0;
      if (st == F_WAIT && cpu_ack == 2'b01 && !LEVEL_MASK[cur]) fclr[cur] = 1'b1;
      if (st == F_SVC && cpu_ack == 2'b10 && LEVEL_MASK[cur]) fclr[cur] = 1'b1;
    end

    assign irq_o = (st == F_WAIT);
    assign irq_addr_o = addr_q;
    assign tbl_rd = in_tbl ? tbl[tbl_off[IW-1:0]] : '0;
  end else begin : g_plain
    assign fclr = '0;
    assign irq_o = mer[0] & |pend;
    assign irq_addr_o = '0;
    assign tbl_rd = '0;
  end

  always_comb
    case (bus_addr)
      A_STAT:  bus_rdata = DW'(stat);
      A_PEND:  bus_rdata = DW'(pend);
      A_EN:    bus_rdata = DW'(en);
      A_VEC:   bus_rdata = found ? DW'(top) : '1;
      A_MODE:  bus_rdata = DW'(mer);
      default: bus_rdata = in_tbl ? tbl_rd : '0;
    endcase
endmodule

module irq_concentrator_chk #(
  parameter bit FAST = 1'b1,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [DW-1:0] irq_addr,
  input logic [1:0]    ack,
  input logic          me
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    FAST && irq |=> !irq || $stable(irq_addr)); // R8
  AST_IRQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    FAST && irq && ack != 2'b01 |=> irq); // R8
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    FAST && irq && ack == 2'b01 |=> !irq); // R9
  AST_PLAIN_NEEDS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    !FAST && irq |-> me); // R5
  AST_RAISE_NEEDS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    FAST && $rose(irq) |-> $past(me)); // R5
endmodule

bind irq_concentrator irq_concentrator_chk #(.FAST(FAST), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .irq_addr(irq_addr_o),
  .ack(cpu_ack), .me(mer[0]));

// File: tb/tb_irq_concentrator.sv
`timescale 1ns/1ps
module tb_irq_concentrator;
  localparam int N = 4;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [N-1:0] LVL = 4'b0011;
  localparam logic [N-1:0] HI  = 4'b0101;

  logic clk = 0, rst_n = 0, wr = 0;
  logic [N-1:0] src = ~HI;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] ack = '0;
  logic [DW-1:0] rd0, rd1, ia0, ia1;
  logic irq0, irq1;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_concentrator #(.N_SRC(N), .DW(DW), .AW(AW), .LEVEL_MASK(LVL), .ACT_HIGH(HI), .FAST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd0), .cpu_ack(ack), .irq_o(irq0), .irq_addr_o(ia0));
  irq_concentrator #(.N_SRC(N), .DW(DW), .AW(AW), .LEVEL_MASK(LVL), .ACT_HIGH(HI), .FAST(1'b0)) dut_plain (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd1), .cpu_ack(ack), .irq_o(irq1), .irq_addr_o(ia1));

  // reference model, index 0 = fast instance, 1 = plain instance
  logic [N-1:0] hist[$];
  logic [N-1:0] m_stat[2], m_en[2];
  logic [1:0] m_mode[2];
  logic [DW-1:0] m_tbl[N];
  int m_st, m_cur;
  logic [DW-1:0] m_addr;

  function automatic int lowest(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {~HI, ~HI, ~HI, ~HI};
      for (int k = 0; k < 2; k++) begin m_stat[k] = 0; m_en[k] = 0; m_mode[k] = 0; end
      for (int i = 0; i < N; i++) m_tbl[i] = 0;
      m_st = 0; m_cur = 0; m_addr = 0;
    end else begin
      logic [N-1:0] ev, nowv, prevv;
      hist.push_front(src);
      nowv = hist[2]; prevv = hist[3];
      void'(hist.pop_back());
      for (int i = 0; i < N; i++)
        if (LVL[i]) ev[i] = (nowv[i] == HI[i]);
        else ev[i] = HI[i] ? (nowv[i] && !prevv[i]) : (!nowv[i] && prevv[i]);
      for (int k = 0; k < 2; k++) begin
        logic [N-1:0] clr, nxt;
        int p;
        clr = (wr && addr == 3) ? wdata[N-1:0] : '0;
        p = lowest(m_stat[k] & m_en[k]);
        if (k == 0) begin
          if (m_st == 1 && ack == 2'b01 && !LVL[m_cur]) clr[m_cur] = 1;
          if (m_st == 2 && ack == 2'b10 && LVL[m_cur]) clr[m_cur] = 1;
          if (m_st == 0 && m_mode[0][0] && p >= 0) begin m_st = 1; m_cur = p; m_addr = m_tbl[p]; end
          else if (m_st == 1 && ack == 2'b01) m_st = 2;
          else if (m_st == 2 && ack == 2'b10) m_st = 0;
        end
        nxt = m_stat[k] & ~clr;
        if (m_mode[k][1]) nxt = nxt | ev;
        else if (wr && addr == 0) nxt = nxt | wdata[N-1:0];
        m_stat[k] = nxt;
        if (wr && addr == 2) m_en[k] = wdata[N-1:0];
        if (wr && addr == 5) m_mode[k] = wdata[1:0];
      end
      if (wr && addr >= 16 && addr < 16 + N) m_tbl[addr - 16] = wdata;
    end
  end

  function automatic logic [DW-1:0] exp_rd(int k, int a);
    int p;
    p = lowest(m_stat[k] & m_en[k]);
    case (a)
      0: return DW'(m_stat[k]);
      1: return DW'(m_stat[k] & m_en[k]);
      2: return DW'(m_en[k]);
      4: return p < 0 ? '1 : DW'(p);
      5: return DW'(m_mode[k]);
      default: return (k == 0 && a >= 16 && a < 16 + N) ? m_tbl[a - 16] : '0;
    endcase
  endfunction

  function automatic string tag(int a);
    case (a)
      0: return "R4 R2 R3";
      1, 4: return "R7";
      3: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R8 fast irq", DW'(irq0), DW'(m_st == 1));
    chk("R8 fast irq_addr", ia0, m_addr);
    chk("R5 plain irq", DW'(irq1), DW'(m_mode[1][0] && |(m_stat[1] & m_en[1])));
    chk("R1 plain irq_addr", ia1, '0);
    chk({tag(int'(addr)), " fast rdata"}, rd0, exp_rd(0, int'(addr)));
    chk({tag(int'(addr)), " plain rdata"}, rd1, exp_rd(1, int'(addr)));
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; wr = 0; ack = 0; end
  endtask
  task automatic bw(int a, logic [DW-1:0] d);
    @(negedge clk); #1; wr = 1; addr = AW'(a); wdata = d; ack = 0;
  endtask
  task automatic rd(int a);
    @(negedge clk); #1; wr = 0; ack = 0; addr = AW'(a);
  endtask
  task automatic pack(logic [1:0] c);
    @(negedge clk); #1; wr = 0; ack = c;
  endtask
  task automatic serve();
    int n = 0;
    step(1);
    while (!irq0 && n < 40) begin step(1); n++; end
    pack(2'b01); step(2); pack(2'b10); step(1);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(4);
    @(negedge clk); rst_n = 1;
    for (int a = 0; a < 6; a++) rd(a);            // R1 reset values
    rd(17);
    for (int i = 0; i < N; i++) bw(16 + i, 32'h1000 + 32'h40 * i);
    rd(18);
    // R4: software sets status while hardware enable is off
    bw(5, 1); bw(2, 'hF); bw(0, 'b0100); rd(4); step(2);
    serve();                                       // R9 edge source cleared on entry
    rd(0); bw(3, 'hF); rd(0);                      // R6
    // R4: writes ignored with hardware enable on
    bw(5, 3); bw(0, 'b0001); rd(0); step(3);
    // R2: level active-high, reasserts after acks
    src[0] = 1; rd(0); step(6); serve(); bw(3, 1); rd(0); step(2);
    src[0] = 0; step(6); serve(); serve(); bw(3, 'hF); rd(0); step(3);
    // R2: level active-low
    src[1] = 0; rd(1); step(6); serve(); src[1] = 1; step(6); serve(); serve(); bw(3, 'hF); step(2);
    // R3 R10: rising and falling edges at once, served in order
    src[2] = 1; src[3] = 0; step(2); src[2] = 0; src[3] = 1; rd(1); step(6); rd(4);
    serve(); rd(4); serve(); rd(4); bw(3, 'hF); step(3);
    // R9: stray codes ignored while request is raised
    src[3] = 0; step(2); src[3] = 1; step(6);
    pack(2'b10); pack(2'b11); step(2); serve(); bw(3, 'hF); step(2);
    // R5: output enable off keeps request low
    bw(5, 2); src[2] = 1; step(2); src[2] = 0; step(6); rd(1);
    bw(5, 3); step(3); serve(); bw(3, 'hF); step(2);
    // R7: masked source pends in status only
    bw(2, 'b1000); src[2] = 1; step(2); src[2] = 0; step(6);
    rd(0); rd(1); rd(4); bw(3, 'b0100); rd(0); step(2);
    rd(9); rd(16 + N);
    step(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule